// File: doc/BRIEF.md
# Byte-Wide Host Port with Address Autoincrement

This block gives an external host access to on-chip word memory over an 8-bit bus. A 16-bit word moves as two byte accesses, and a half-select input picks the high or the low byte. The host sees four register codes. One is the control register, which holds the interrupt flags. One is the address register. The other two reach memory through the address register: one advances the address after each complete word, and the other leaves it unchanged. Host accesses run on the local clock. The host data bus is split into an input byte, an output byte and an output-enable, so the tristate pad stays outside the block.

Memory has a single port, which the host and the local processor share. When both request it in the same cycle, the host's access goes to memory and the processor is held with a stall output for that cycle. It then retries. The control register carries two flags, one in each direction. The side that raises a flag sets it by writing 1, and the other side lowers it by writing 1 to the same bit.

The host request side is valid/ready. An access is taken on a cycle where `h_valid` and `h_ready` are both high. `h_ready` falls while local reset is asserted, which refuses every access. It also falls for the one cycle in which a memory word is being fetched. `h_valid` and the request fields must stay steady until the access is taken. A read answers with a single-cycle `h_rvalid` pulse. There is no back-pressure on that response, so the host must take it when it comes.

Top module: `host_byte_port`

## Requirements
- R1: While `rst_n` is low, `h_ready` is low. After reset, both interrupt flags are 0, `h_rvalid` is 0 and the address register reads 0.
- R2: Register code 01 is the address register. Half 0 is the high byte and holds address bits AW-1..8, with unused bits reading 0. Half 1 is the low byte.
- R3: With code 10 or 11, a half-0 write only stores the high byte, and the block makes no memory access of its own. A half-1 write stores {high byte, written byte} to memory at the current address in that same cycle.
- R4: With code 10 or 11, a half-0 read fetches the word at the current address. `h_ready` is low in the next cycle, and the high byte is returned two cycles after the access is taken. A half-1 read returns the low byte of the fetched word and makes no memory access.
- R5: Code 10 advances the address by one after each half-1 access, whether read or write. Code 11 never changes the address.
- R6: Advancing from address 2^AW-1 wraps to 0.
- R7: When a host memory access and a processor request (`cpu_req`) fall in the same cycle, memory gets the host's address, data and write enable, and `cpu_stall` is high. `cpu_stall` is low in every other cycle.
- R8: Code 00 half 1 is the control byte. Bit 0 is the flag to the processor (`irq_to_cpu`), which the host sets and the processor clears. Bit 1 is the flag to the host (`irq_to_host`), which the processor sets and the host clears. In every case the action is a write of 1 to that bit, and writing 0 changes nothing.
- R9: When one side sets a flag in the same cycle that the other side clears it, the flag ends up set.
- R10: A read of control half 1 returns {6'b0, irq_to_host, irq_to_cpu}. Control half 0 reads 0, and writes to it have no effect.
- R11: Every read other than a data half-0 read returns its byte with `h_rvalid` one cycle after the access is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Local reset, active low, asynchronous |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Block can take a host access |
| h_write | input | 1 | 1 = write, 0 = read |
| h_reg | input | 2 | Register code: 00 control, 01 address, 10 data with increment, 11 data fixed |
| h_half | input | 1 | 0 = high byte, 1 = low byte |
| h_wdata | input | 8 | Host write byte |
| h_rvalid | output | 1 | Read byte valid, one-cycle pulse |
| h_rdata | output | 8 | Host read byte |
| h_doe | output | 1 | Pad output enable, same as h_rvalid |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | 16 | Processor write word |
| cpu_stall | output | 1 | Processor must repeat its request |
| cpu_flag_wr | input | 1 | Processor write to control flags |
| cpu_flag_wdata | input | 2 | Processor flag write bits (bit 0 clears irq_to_cpu, bit 1 sets irq_to_host) |
| irq_to_cpu | output | 1 | Interrupt toward the processor |
| irq_to_host | output | 1 | Interrupt toward the host |
| ram_en | output | 1 | Memory access strobe |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | AW | Memory word address |
| ram_wdata | output | 16 | Memory write word |
| ram_rdata | input | 16 | Memory read word, one cycle after ram_en |

## Verification
The bench builds the block with AW = 9, so memory holds 512 words. With that width, the wrap from the last word back to 0 can be reached with a single address load. It also makes the address high byte only partly populated, which lets the bench check that the unused bits read 0. The bench keeps the default byte width of 8, and its small memory model returns data one cycle after each access, which matches the latency the fetch path expects.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;
  typedef enum logic [1:0] {
    REG_CTRL     = 2'b00,
    REG_ADDR     = 2'b01,
    REG_DATA_INC = 2'b10,
    REG_DATA_FIX = 2'b11
  } hreg_e;

  localparam int FLAG_N       = 2;
  localparam int FLAG_TO_CPU  = 0;
  localparam int FLAG_TO_HOST = 1;
endpackage

// File: rtl/hbp_flags.sv
`timescale 1ns/1ps
module hbp_flags
  import hbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [FLAG_N-1:0] host_bits,
  input  logic              cpu_wr,
  input  logic [FLAG_N-1:0] cpu_bits,
  output logic [FLAG_N-1:0] flags
);
  // Which side raises each flag; the opposite side lowers it.
  localparam logic [FLAG_N-1:0] HOST_RAISES = FLAG_N'(1) << FLAG_TO_CPU;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic set_i, clr_i;
    always_comb begin
      if (HOST_RAISES[i]) begin
        set_i = host_wr & host_bits[i];
        clr_i = cpu_wr  & cpu_bits[i];
      end else begin
        set_i = cpu_wr  & cpu_bits[i];
        clr_i = host_wr & host_bits[i];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flags[i] <= 1'b0;
      else if (set_i) flags[i] <= 1'b1;   // raise beats lower
      else if (clr_i) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hbp_ram_arb.sv
`timescale 1ns/1ps
module hbp_ram_arb #(
  parameter int AW = 10,
  parameter int WW = 16
) (
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [WW-1:0] host_wdata,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [WW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [WW-1:0] ram_wdata
);
  always_comb begin
    cpu_stall = host_req & cpu_req;
    ram_en    = host_req | cpu_req;
    if (host_req) begin
      ram_we    = host_we;
      ram_addr  = host_addr;
      ram_wdata = host_wdata;
    end else begin
      ram_we    = cpu_req & cpu_we;
      ram_addr  = cpu_addr;
      ram_wdata = cpu_wdata;
    end
  end
endmodule

// File: rtl/host_byte_port.sv
`timescale 1ns/1ps
module host_byte_port
  import hbp_pkg::*;
#(
  parameter int AW = 10,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_write,
  input  logic [1:0]    h_reg,
  input  logic          h_half,
  input  logic [BW-1:0] h_wdata,
  output logic          h_rvalid,
  output logic [BW-1:0] h_rdata,
  output logic          h_doe,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [2*BW-1:0] cpu_wdata,
  output logic          cpu_stall,
  input  logic          cpu_flag_wr,
  input  logic [1:0]    cpu_flag_wdata,
  output logic          irq_to_cpu,
  output logic          irq_to_host,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [2*BW-1:0] ram_wdata,
  input  logic [2*BW-1:0] ram_rdata
);
  localparam int WW = 2 * BW;
  localparam int HW = AW - BW;                 // address bits held in the high byte
  localparam logic [AW-1:0] STEP = AW'(1);

  hreg_e          reg_sel;
  logic           take, is_data, bump;
  logic           data_rd_hi, data_wr_lo, ctrl_wr;
  logic [AW-1:0]  addr_q;
  logic [BW-1:0]  hi_buf_q;
  logic [WW-1:0]  word_q;
  logic           fetch_q;
  logic           rvalid_q;
  logic [BW-1:0]  rdata_q;
  logic [FLAG_N-1:0] flags;

  assign reg_sel    = hreg_e'(h_reg);
  assign h_ready    = rst_n & ~fetch_q;
  assign take       = h_valid & h_ready;
  assign is_data    = (reg_sel == REG_DATA_INC) || (reg_sel == REG_DATA_FIX);
  assign data_rd_hi = take & is_data & ~h_write & ~h_half;
  assign data_wr_lo = take & is_data &  h_write &  h_half;
  assign bump       = take & h_half & (reg_sel == REG_DATA_INC);
  assign ctrl_wr    = take & h_write & h_half & (reg_sel == REG_CTRL);

  hbp_ram_arb #(.AW(AW), .WW(WW)) u_arb (
    .host_req  (data_rd_hi | data_wr_lo),
    .host_we   (data_wr_lo),
    .host_addr (addr_q),
    .host_wdata({hi_buf_q, h_wdata}),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_stall (cpu_stall),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  hbp_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (ctrl_wr),
    .host_bits(h_wdata[FLAG_N-1:0]),
    .cpu_wr   (cpu_flag_wr),
    .cpu_bits (cpu_flag_wdata),
    .flags    (flags)
  );

  assign irq_to_cpu  = flags[FLAG_TO_CPU];
  assign irq_to_host = flags[FLAG_TO_HOST];

  // Host register file and read response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      hi_buf_q <= '0;
      word_q   <= '0;
      fetch_q  <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      fetch_q  <= data_rd_hi;
      if (fetch_q) begin
        word_q   <= ram_rdata;
        rdata_q  <= ram_rdata[WW-1:BW];
        rvalid_q <= 1'b1;
      end
      if (take) begin
        unique case (reg_sel)
          REG_CTRL: begin
            if (!h_write) begin
              rdata_q  <= h_half ? BW'(flags) : '0;
              rvalid_q <= 1'b1;
            end
          end
          REG_ADDR: begin
            if (h_write) begin
              if (h_half) addr_q[BW-1:0]  <= h_wdata;
              else        addr_q[AW-1:BW] <= h_wdata[HW-1:0];
            end else begin
              rdata_q  <= h_half ? addr_q[BW-1:0] : BW'(addr_q >> BW);
              rvalid_q <= 1'b1;
            end
          end
          default: begin
            if (h_write && !h_half) hi_buf_q <= h_wdata;
            if (!h_write && h_half) begin
              rdata_q  <= word_q[BW-1:0];
              rvalid_q <= 1'b1;
            end
            if (bump) addr_q <= addr_q + STEP;
          end
        endcase
      end
    end
  end

  assign h_rvalid = rvalid_q;
  assign h_rdata  = rdata_q;
  assign h_doe    = rvalid_q;
endmodule

// File: rtl/hbp_checker.sv
`timescale 1ns/1ps
module hbp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       h_valid,
  input logic       h_ready,
  input logic       h_write,
  input logic [1:0] h_reg,
  input logic       h_half,
  input logic [7:0] h_wdata,
  input logic       h_rvalid,
  input logic       cpu_req,
  input logic       cpu_stall,
  input logic       ram_en,
  input logic       irq_to_cpu
);
  logic took, rd_hi_data, wr_hi_data, short_rd, set_to_cpu;
  assign took       = h_valid && h_ready;
  assign rd_hi_data = took && !h_write && h_reg[1] && !h_half;
  assign wr_hi_data = took &&  h_write && h_reg[1] && !h_half;
  assign short_rd   = took && !h_write && !(h_reg[1] && !h_half);
  assign set_to_cpu = took && h_write && (h_reg == 2'b00) && h_half && h_wdata[0];

  p_ready_low_in_reset_r1: assert property (@(posedge clk) !rst_n |-> !h_ready);

  p_hi_write_no_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_data |-> (!cpu_stall && (ram_en == cpu_req)));

  p_fetch_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_data |=> !h_ready);

  p_fetch_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_hi_data, 2) |-> h_rvalid);

  p_stall_only_on_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (cpu_req && ram_en));

  p_host_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_to_cpu |=> irq_to_cpu);

  p_short_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    short_rd |=> h_rvalid);
endmodule

bind host_byte_port hbp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
  .h_write(h_write), .h_reg(h_reg), .h_half(h_half), .h_wdata(h_wdata),
  .h_rvalid(h_rvalid), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
  .ram_en(ram_en), .irq_to_cpu(irq_to_cpu)
);

// File: tb/host_byte_port_bench.sv
`timescale 1ns/1ps
module host_byte_port_bench;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] C_CTRL = 2'b00, C_ADDR = 2'b01, C_INC = 2'b10, C_FIX = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_valid = 1'b0, h_write = 1'b0, h_half = 1'b0;
  logic [1:0] h_reg = 2'b00;
  logic [7:0] h_wdata = 8'h00;
  logic h_ready, h_rvalid, h_doe;
  logic [7:0] h_rdata;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_flag_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [1:0] cpu_flag_wdata = 2'b00;
  logic cpu_stall, irq_to_cpu, irq_to_host, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;

  always #4 clk = ~clk;

  host_byte_port #(.AW(AW)) u_host_byte_port (.*);

  logic [15:0] mem [DEPTH];
  always_ff @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  int total = 0, bad = 0;
  logic [15:0] exp_mem [DEPTH];
  logic [AW-1:0] m_addr = '0;
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic seen_en, seen_we, seen_stall;
  logic [AW-1:0] seen_addr;
  logic [15:0] seen_wdata;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) if (rst_n && h_rvalid) begin
    if (exp_q.size() == 0) check(1'b0, "R11 unexpected response", h_rdata, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(h_rdata == e, t, h_rdata, e);
    end
  end

  task automatic expect_byte(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic acc(input logic w, input logic [1:0] r, input logic hf, input logic [7:0] d);
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_valid = 1'b1; h_write = w; h_reg = r; h_half = hf; h_wdata = d;
    #1;
    seen_en = ram_en; seen_we = ram_we; seen_stall = cpu_stall;
    seen_addr = ram_addr; seen_wdata = ram_wdata;
    @(negedge clk);
    h_valid = 1'b0;
    if (!w && r[1] && !hf) begin
      check(h_ready == 1'b0, "R4 ready low during fetch", h_ready, 0);
      check(h_rvalid == 1'b0, "R4 no early answer", h_rvalid, 0);
    end else if (!w) begin
      check(h_rvalid == 1'b1, "R11 one-cycle read latency", h_rvalid, 1);
    end
  endtask

  task automatic set_addr(input logic [15:0] a);
    acc(1'b1, C_ADDR, 1'b0, a[15:8]);
    acc(1'b1, C_ADDR, 1'b1, a[7:0]);
    m_addr = a[AW-1:0];
  endtask

  task automatic wr_word(input logic [1:0] r, input logic [15:0] v);
    acc(1'b1, r, 1'b0, v[15:8]);
    check(seen_en == 1'b0, "R3 high byte makes no access", seen_en, 0);
    acc(1'b1, r, 1'b1, v[7:0]);
    check(seen_en && seen_we && seen_addr == m_addr && seen_wdata == v,
          "R3 word write on low byte", seen_wdata, v);
    exp_mem[m_addr] = v;
    if (r == C_INC) m_addr = m_addr + 1'b1;
  endtask

  task automatic rd_word(input logic [1:0] r, input string t);
    expect_byte(exp_mem[m_addr][15:8], {t, " high"});
    acc(1'b0, r, 1'b0, 8'h00);
    expect_byte(exp_mem[m_addr][7:0], {t, " low"});
    acc(1'b0, r, 1'b1, 8'h00);
    check(seen_en == 1'b0, "R4 low byte from latch", seen_en, 0);
    if (r == C_INC) m_addr = m_addr + 1'b1;
  endtask

  task automatic rd_addr(input logic [15:0] e, input string t);
    expect_byte(e[15:8], t);
    acc(1'b0, C_ADDR, 1'b0, 8'h00);
    expect_byte(e[7:0], t);
    acc(1'b0, C_ADDR, 1'b1, 8'h00);
  endtask

  task automatic cpu_flags(input logic [1:0] b);
    @(negedge clk);
    cpu_flag_wr = 1'b1; cpu_flag_wdata = b;
    @(negedge clk);
    cpu_flag_wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    check(h_ready == 1'b0, "R1 ready low in reset", h_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!irq_to_cpu && !irq_to_host && !h_rvalid, "R1 reset outputs",
          {irq_to_host, irq_to_cpu, h_rvalid}, 0);
    rd_addr(16'h0000, "R1 address after reset");

    // R2 address register halves
    set_addr(16'h01A5);
    rd_addr(16'h01A5, "R2 address readback");
    acc(1'b1, C_ADDR, 1'b0, 8'hFF);
    m_addr[8] = 1'b1;
    rd_addr(16'h01A5, "R2 unused address bits read 0");

    // R3/R5 incrementing writes, reads
    set_addr(16'h0005);
    wr_word(C_INC, 16'h1234);
    wr_word(C_INC, 16'hABCD);
    rd_addr(16'h0007, "R5 address advanced by two");
    set_addr(16'h0005);
    rd_word(C_INC, "R4 read word 5");
    rd_word(C_INC, "R4 read word 6");
    // R5 fixed code keeps address
    set_addr(16'h0020);
    wr_word(C_FIX, 16'h1111);
    wr_word(C_FIX, 16'h5A3C);
    rd_word(C_FIX, "R5 fixed read");
    rd_addr(16'h0020, "R5 fixed leaves address");

    // R6 wrap
    set_addr(16'h01FF);
    wr_word(C_INC, 16'hBEEF);
    rd_addr(16'h0000, "R6 wrap to zero");
    set_addr(16'h01FF);
    rd_word(C_FIX, "R6 last word");

    // R7 contention
    set_addr(16'h0040);
    acc(1'b1, C_INC, 1'b0, 8'hC0);
    cpu_addr = 9'h041; cpu_wdata = 16'h7777; cpu_we = 1'b1; cpu_req = 1'b1;
    acc(1'b1, C_INC, 1'b1, 8'hDE);
    check(seen_stall == 1'b1, "R7 stall on clash", seen_stall, 1);
    check(seen_addr == 9'h040 && seen_wdata == 16'hC0DE, "R7 host owns memory",
          seen_wdata, 16'hC0DE);
    exp_mem[9'h040] = 16'hC0DE; m_addr = 9'h041;
    #1;
    check(cpu_stall == 1'b0, "R7 no stall without host", cpu_stall, 0);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    exp_mem[9'h041] = 16'h7777;
    set_addr(16'h0040);
    rd_word(C_INC, "R7 host word kept");
    rd_word(C_INC, "R7 processor word after retry");

    // R8/R10 flags
    acc(1'b1, C_CTRL, 1'b1, 8'h01);
    check(irq_to_cpu == 1'b1, "R8 host raises processor flag", irq_to_cpu, 1);
    acc(1'b1, C_CTRL, 1'b1, 8'h00);
    check(irq_to_cpu == 1'b1, "R8 write of 0 keeps flag", irq_to_cpu, 1);
    cpu_flags(2'b01);
    check(irq_to_cpu == 1'b0, "R8 processor clears flag", irq_to_cpu, 0);
    cpu_flags(2'b10);
    check(irq_to_host == 1'b1, "R8 processor raises host flag", irq_to_host, 1);
    acc(1'b1, C_CTRL, 1'b0, 8'h03);
    check(irq_to_host && !irq_to_cpu, "R10 high control half ignored",
          {irq_to_host, irq_to_cpu}, 2);
    expect_byte(8'h02, "R10 control low reads flags");
    acc(1'b0, C_CTRL, 1'b1, 8'h00);
    expect_byte(8'h00, "R10 control high reads 0");
    acc(1'b0, C_CTRL, 1'b0, 8'h00);
    acc(1'b1, C_CTRL, 1'b1, 8'h02);
    check(irq_to_host == 1'b0, "R8 host clears host flag", irq_to_host, 0);

    // R9 set beats clear in same cycle
    @(negedge clk);
    h_valid = 1'b1; h_write = 1'b1; h_reg = C_CTRL; h_half = 1'b1; h_wdata = 8'h01;
    cpu_flag_wr = 1'b1; cpu_flag_wdata = 2'b01;
    @(negedge clk);
    h_valid = 1'b0; cpu_flag_wr = 1'b0;
    check(irq_to_cpu == 1'b1, "R9 set wins over clear", irq_to_cpu, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    check(1'b0, "R1 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule